// File: doc/BRIEF.md
# DS3 PLCP Frame Transmitter

This block wraps a stream of 53-byte ATM cells into PLCP frames for a DS3 framer downstream. Every frame holds twelve rows, and each row carries one cell. A row opens with two fixed alignment bytes, an identifier byte that counts down from 11 to 0, and one path-overhead byte. A trailer of 0xC nibbles closes the frame. The trailer length follows a three-frame stuffing pattern that the block runs by itself. The output is one nibble for each slot strobe (`tick`) given by the framer. The block pulls cell bytes from an upstream source with a take strobe, so the source must hold `cell_data` stable until that strobe.

Three path-overhead bytes are produced by the block itself. B1 is a byte-wise even parity taken over the previous frame. C1 names the stuffing phase of the frame it sits in. G1 carries the far-end error count, the yellow bit and link-status bits that the receive side supplies. The other overhead rows are zero. When override is enabled, these rows take a byte shifted in serially instead. With `plcp_en` low the framing stage is bypassed and cells leave back to back, one nibble at a time.

Top module: `plcp_tx`

## Requirements
- R1: While and right after reset, with `tick` low, `tx_vld`, `tx_sof` and `cell_take` are 0.
- R2: With `plcp_en` high, each row is sent as 57 bytes, high nibble first: byte 0 = 0xF6, byte 1 = 0x28, byte 2 = identifier, byte 3 = path overhead, bytes 4..56 = one cell. Each nibble appears on `tx_nib` with `tx_vld` high in the cycle after the `tick` that produced it.
- R3: The identifier in row r (r = 0..11, in sending order) is formed from k = 11 − r as {k[3:0], 3'b000, p}, where p makes the byte's parity even.
- R4: `cell_take` is high only in the `tick` cycle of a cell byte's low nibble. Both nibbles come from the `cell_data` held at that time. A frame takes exactly 12 × 53 bytes.
- R5: After row 11, a trailer of 0xC nibbles follows. The frame phase runs 0,1,2,0,… from reset or enable, and the trailer is 13, 14 and 13 nibbles for phases 0, 1 and 2.
- R6: The overhead byte of row 11 (C1) is 0xFF, 0x00 or 0x66 for phases 0, 1 and 2.
- R7: The overhead byte of row 7 (B1) is the XOR of all overhead and cell bytes sent in rows 0..11 of the previous frame. It is 0x00 in the first frame after reset or enable.
- R8: The overhead byte of row 8 (G1) is {rx_febe[3:0], rx_yellow, rx_link[2:0]}, sampled at that byte's high-nibble tick.
- R9: The overhead bytes of rows 0..6, 9 and 10 are 0x00 when `oh_ext` is low. When `oh_ext` is high they equal the last 8 bits shifted in on `ser_bit` with `ser_en`, MSB first, the newest bit in bit 0.
- R10: With `plcp_en` low, each tick sends the next cell nibble, high then low, with no overhead and no `tx_sof`. Raising `plcp_en` restarts at row 0 and phase 0.
- R11: `tx_sof` is high exactly with the high nibble of the first alignment byte of row 0.
- R12: `tx_vld` is high in a cycle if and only if `tick` was high in the cycle before, and a cycle without a tick leaves the frame position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| plcp_en | input | 1 | 1 = PLCP framing, 0 = direct cell bypass |
| tick | input | 1 | Output nibble slot strobe from the framer |
| cell_data | input | 8 | Current cell byte, held until taken |
| cell_take | output | 1 | Current cell byte consumed at this edge |
| oh_ext | input | 1 | Use the serial byte for the spare overhead rows |
| ser_en | input | 1 | Shift strobe for the serial overhead input |
| ser_bit | input | 1 | Serial overhead data, MSB first |
| rx_febe | input | 4 | Far-end block error count for G1 |
| rx_yellow | input | 1 | Yellow alarm bit for G1 |
| rx_link | input | 3 | Link status bits for G1 |
| tx_nib | output | 4 | Output nibble |
| tx_vld | output | 1 | `tx_nib` holds a new nibble |
| tx_sof | output | 1 | Nibble is the start of a frame |

## Verification
A wrong row or nibble counter misplaces the 0xF6/0x28 alignment pattern or the identifier byte at the very next row boundary, within 114 nibbles. A wrong phase counter shows up within one frame as a trailer of the wrong length or a mismatched C1. A wrong parity accumulator is only visible one frame later, in B1. A wrong cell handshake shifts every cell byte that follows, so the cell payload the bench expects is off from the first cell on.

// File: rtl/plcp_pkg.sv
package plcp_pkg;
   localparam logic [7:0] FRM_A1  = 8'hF6;
   localparam logic [7:0] FRM_A2  = 8'h28;
   localparam logic [3:0] TRL_NIB = 4'hC;

   typedef enum logic [2:0] {SL_A1, SL_A2, SL_POI, SL_POH, SL_CELL, SL_TRL} slot_e;

   // identifier byte: index in the high nibble, even-parity bit in bit 0
   function automatic logic [7:0] poi_code(input logic [3:0] k);
      poi_code = {k, 3'b000, ^k};
   endfunction

   // stuff-phase marker
   function automatic logic [7:0] c1_code(input logic [1:0] ph);
      case (ph)
         2'd0:    c1_code = 8'hFF;
         2'd1:    c1_code = 8'h00;
         default: c1_code = 8'h66;
      endcase
   endfunction
endpackage

// File: rtl/plcp_seq.sv
module plcp_seq
   import plcp_pkg::*;
#(
   parameter int ROWS       = 12,
   parameter int CELL_BYTES = 53,
   parameter int TRL_SHORT  = 13,
   localparam int RW        = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          tick,
   output logic [RW-1:0] row,
   output slot_e         slot,
   output logic          hi,
   output logic [1:0]    phase,
   output logic          frm_first,
   output logic          frm_last
);
   localparam int ROW_NIB = 2 * (4 + CELL_BYTES);
   localparam int NW      = $clog2(ROW_NIB);
   localparam int TW      = $clog2(TRL_SHORT + 2);

   logic [NW-1:0] nib;
   logic          in_trl;
   logic [TW-1:0] trl_cnt;
   logic [TW-1:0] trl_len;
   logic [NW-2:0] byte_idx;

   assign trl_len  = (phase == 2'd1) ? TW'(TRL_SHORT + 1) : TW'(TRL_SHORT);
   assign byte_idx = nib[NW-1:1];
   assign hi       = ~nib[0];

   always_comb begin
      if (in_trl)                           slot = SL_TRL;
      else if (byte_idx == '0)              slot = SL_A1;
      else if (byte_idx == (NW-1)'(1))      slot = SL_A2;
      else if (byte_idx == (NW-1)'(2))      slot = SL_POI;
      else if (byte_idx == (NW-1)'(3))      slot = SL_POH;
      else                                  slot = SL_CELL;
   end

   assign frm_first = !in_trl && (row == '0) && (nib == '0);
   assign frm_last  = in_trl && (trl_cnt == trl_len - TW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         nib     <= '0;
         row     <= '0;
         in_trl  <= 1'b0;
         trl_cnt <= '0;
         phase   <= 2'd0;
      end else if (tick) begin
         if (!in_trl) begin
            if (nib == NW'(ROW_NIB - 1)) begin
               nib <= '0;
               if (row == RW'(ROWS - 1)) begin
                  row     <= '0;
                  in_trl  <= 1'b1;
                  trl_cnt <= '0;
               end else begin
                  row <= row + RW'(1);
               end
            end else begin
               nib <= nib + NW'(1);
            end
         end else if (frm_last) begin
            in_trl  <= 1'b0;
            trl_cnt <= '0;
            phase   <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
         end else begin
            trl_cnt <= trl_cnt + TW'(1);
         end
      end
   end
endmodule

// File: rtl/plcp_bip.sv
module plcp_bip #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         acc_en,
   input  logic [W-1:0] din,
   input  logic         close,
   output logic [W-1:0] parity
);
   logic [W-1:0] acc;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         acc    <= '0;
         parity <= '0;
      end else if (close) begin
         parity <= acc ^ (acc_en ? din : '0);
         acc    <= '0;
      end else if (acc_en) begin
         acc <= acc ^ din;
      end
   end
endmodule

// File: rtl/plcp_ohser.sv
module plcp_ohser #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift,
   input  logic         din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (shift) q <= {q[W-2:0], din};
   end
endmodule

// File: rtl/plcp_tx.sv
module plcp_tx
   import plcp_pkg::*;
#(
   parameter int ROWS       = 12,
   parameter int CELL_BYTES = 53,
   parameter int TRL_SHORT  = 13,
   parameter int B1_ROW     = 7,
   parameter int G1_ROW     = 8,
   parameter int C1_ROW     = 11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       plcp_en,
   input  logic       tick,
   input  logic [7:0] cell_data,
   output logic       cell_take,
   input  logic       oh_ext,
   input  logic       ser_en,
   input  logic       ser_bit,
   input  logic [3:0] rx_febe,
   input  logic       rx_yellow,
   input  logic [2:0] rx_link,
   output logic [3:0] tx_nib,
   output logic       tx_vld,
   output logic       tx_sof
);
   localparam int RW = $clog2(ROWS);

   generate
      if (ROWS < 2 || ROWS > 16) begin : g_bad_rows
         $error("ROWS must fit the 4-bit identifier index");
      end
      if (B1_ROW >= ROWS || G1_ROW >= ROWS || C1_ROW >= ROWS) begin : g_bad_oh_row
         $error("overhead rows must lie inside the frame");
      end
      if (B1_ROW == G1_ROW || B1_ROW == C1_ROW || G1_ROW == C1_ROW) begin : g_oh_clash
         $error("overhead rows must be distinct");
      end
      if (TRL_SHORT < 1 || CELL_BYTES < 1) begin : g_bad_len
         $error("trailer and cell lengths must be positive");
      end
   endgenerate

   logic [RW-1:0] row;
   slot_e         slot;
   logic          hi;
   logic [1:0]    phase;
   logic          frm_first;
   logic          frm_last;
   logic          byp_lo;
   logic [7:0]    poh_val;
   logic [7:0]    poh_hold;
   logic [7:0]    b1_val;
   logic [7:0]    sr_q;
   logic [7:0]    cur_byte;
   logic [3:0]    nib_val;
   logic [3:0]    poi_k;
   logic          bip_en;

   plcp_seq #(.ROWS(ROWS), .CELL_BYTES(CELL_BYTES), .TRL_SHORT(TRL_SHORT)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(plcp_en), .tick(tick),
      .row(row), .slot(slot), .hi(hi), .phase(phase),
      .frm_first(frm_first), .frm_last(frm_last)
   );

   plcp_ohser #(.W(8)) u_ser (
      .clk(clk), .rst_n(rst_n), .shift(ser_en), .din(ser_bit), .q(sr_q)
   );

   assign bip_en = tick && plcp_en && !hi && (slot == SL_POH || slot == SL_CELL);

   plcp_bip #(.W(8)) u_bip (
      .clk(clk), .rst_n(rst_n), .clr(!plcp_en), .acc_en(bip_en),
      .din((slot == SL_POH) ? poh_hold : cell_data),
      .close(tick && plcp_en && frm_last), .parity(b1_val)
   );

   assign poi_k = 4'(ROWS - 1) - 4'(row);

   always_comb begin
      if (row == RW'(B1_ROW))      poh_val = b1_val;
      else if (row == RW'(G1_ROW)) poh_val = {rx_febe, rx_yellow, rx_link};
      else if (row == RW'(C1_ROW)) poh_val = c1_code(phase);
      else                         poh_val = oh_ext ? sr_q : 8'h00;
   end

   always_comb begin
      case (slot)
         SL_A1:   cur_byte = FRM_A1;
         SL_A2:   cur_byte = FRM_A2;
         SL_POI:  cur_byte = poi_code(poi_k);
         SL_POH:  cur_byte = hi ? poh_val : poh_hold;
         SL_CELL: cur_byte = cell_data;
         default: cur_byte = 8'h00;
      endcase
      if (!plcp_en)              nib_val = byp_lo ? cell_data[3:0] : cell_data[7:4];
      else if (slot == SL_TRL)   nib_val = TRL_NIB;
      else                       nib_val = hi ? cur_byte[7:4] : cur_byte[3:0];
   end

   assign cell_take = tick && (plcp_en ? (slot == SL_CELL && !hi) : byp_lo);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_vld   <= 1'b0;
         tx_sof   <= 1'b0;
         tx_nib   <= 4'h0;
         poh_hold <= 8'h00;
         byp_lo   <= 1'b0;
      end else begin
         tx_vld <= tick;
         tx_sof <= tick && plcp_en && frm_first;
         if (tick) tx_nib <= nib_val;
         if (tick && plcp_en && slot == SL_POH && hi) poh_hold <= poh_val;
         if (plcp_en)   byp_lo <= 1'b0;
         else if (tick) byp_lo <= ~byp_lo;
      end
   end
endmodule

// File: rtl/plcp_tx_chk.sv
module plcp_tx_chk #(
   parameter int TAKES = 636
) (
   input logic       clk,
   input logic       rst_n,
   input logic       plcp_en,
   input logic       tick,
   input logic       cell_take,
   input logic       tx_vld,
   input logic       tx_sof,
   input logic [3:0] tx_nib
);
   localparam int CW = $clog2(TAKES + 2);
   logic [CW-1:0] take_cnt;
   logic          seen_sof;

   always_ff @(posedge clk) begin
      if (!rst_n || !plcp_en) begin
         take_cnt <= '0;
         seen_sof <= 1'b0;
      end else if (tx_sof) begin
         take_cnt <= cell_take ? CW'(1) : '0;
         seen_sof <= 1'b1;
      end else if (cell_take) begin
         take_cnt <= take_cnt + CW'(1);
      end
   end

   a_r12_vld_after_tick: assert property (@(posedge clk) disable iff (!rst_n) tick |=> tx_vld);
   a_r12_idle_no_vld:    assert property (@(posedge clk) disable iff (!rst_n) !tick |=> !tx_vld);
   a_r4_take_in_tick:    assert property (@(posedge clk) disable iff (!rst_n) cell_take |-> tick);
   a_r11_sof_is_a1:      assert property (@(posedge clk) disable iff (!rst_n) tx_sof |-> (tx_vld && tx_nib == 4'hF));
   a_r10_bypass_no_sof:  assert property (@(posedge clk) disable iff (!rst_n) !plcp_en |=> !tx_sof);
   a_r4_takes_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
                                          (tx_sof && seen_sof && plcp_en) |-> (take_cnt == CW'(TAKES)));
endmodule

bind plcp_tx plcp_tx_chk #(.TAKES(ROWS * CELL_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .plcp_en(plcp_en), .tick(tick), .cell_take(cell_take),
   .tx_vld(tx_vld), .tx_sof(tx_sof), .tx_nib(tx_nib)
);

// File: tb/plcp_tx_bench.sv
`timescale 1ns/1ps
module plcp_tx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       plcp_en = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] cell_data;
   logic       cell_take;
   logic       oh_ext = 1'b0;
   logic       ser_en = 1'b0;
   logic       ser_bit = 1'b0;
   logic [3:0] rx_febe = 4'h0;
   logic       rx_yellow = 1'b0;
   logic [2:0] rx_link = 3'h0;
   logic [3:0] tx_nib;
   logic       tx_vld;
   logic       tx_sof;

   logic [7:0] src;
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // bench model state
   bit       tick_prev = 0;
   bit       m_en = 0;
   bit       m_bl = 0;
   bit       m_intrl = 0;
   int       m_row = 0, m_nib = 0, m_trl = 0, m_ph = 0;
   logic [7:0] m_acc = 0, m_b1 = 0, m_cell = 0, m_poh = 0, m_sr = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic [7:0]  g = 8'h00;

   always #2.5 clk = ~clk;

   plcp_tx u_plcp_tx (
      .clk(clk), .rst_n(rst_n), .plcp_en(plcp_en), .tick(tick),
      .cell_data(cell_data), .cell_take(cell_take), .oh_ext(oh_ext),
      .ser_en(ser_en), .ser_bit(ser_bit), .rx_febe(rx_febe),
      .rx_yellow(rx_yellow), .rx_link(rx_link),
      .tx_nib(tx_nib), .tx_vld(tx_vld), .tx_sof(tx_sof)
   );

   always @(posedge clk) begin
      if (!rst_n)         src <= 8'h00;
      else if (cell_take) src <= src + 8'h01;
   end
   assign cell_data = src;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic model_reset_frame();
      m_row = 0; m_nib = 0; m_trl = 0; m_ph = 0; m_intrl = 0;
      m_acc = 0; m_b1 = 0;
   endtask

   task automatic model_vld();
      int b;
      bit hi;
      logic [7:0] eb;
      logic [3:0] k;
      string tg;
      if (!m_en) begin
         chk("R10 bypass nibble", tx_nib, m_bl ? m_cell[3:0] : m_cell[7:4]);
         chk("R10 bypass no start marker", tx_sof, 0);
         if (m_bl) m_cell++;
         m_bl = !m_bl;
         return;
      end
      if (m_intrl) begin
         chk("R5 trailer nibble", tx_nib, 4'hC);
         chk("R11 no start marker in trailer", tx_sof, 0);
         m_trl++;
         if (m_trl == ((m_ph == 1) ? 14 : 13)) begin
            m_intrl = 0; m_trl = 0;
            m_b1 = m_acc; m_acc = 0;
            m_ph = (m_ph + 1) % 3;
         end
         return;
      end
      b  = m_nib / 2;
      hi = (m_nib % 2 == 0);
      chk("R11 start marker", tx_sof, (m_row == 0 && m_nib == 0) ? 1 : 0);
      if (b == 0) begin
         eb = 8'hF6; tg = "R2 first alignment byte";
      end else if (b == 1) begin
         eb = 8'h28; tg = "R2 second alignment byte";
      end else if (b == 2) begin
         k  = 4'(11 - m_row);
         eb = {k, 3'b000, ^k}; tg = "R3 identifier";
      end else if (b == 3) begin
         if (hi) begin
            if (m_row == 7)       m_poh = m_b1;
            else if (m_row == 8)  m_poh = {rx_febe, rx_yellow, rx_link};
            else if (m_row == 11) m_poh = (m_ph == 0) ? 8'hFF : (m_ph == 1) ? 8'h00 : 8'h66;
            else                  m_poh = oh_ext ? m_sr : 8'h00;
         end
         eb = m_poh;
         if (m_row == 7)       tg = "R7 B1 parity";
         else if (m_row == 8)  tg = "R8 G1 status";
         else if (m_row == 11) tg = "R6 C1 phase";
         else                  tg = "R9 spare overhead";
      end else begin
         eb = m_cell; tg = "R4 cell byte";
      end
      chk(tg, tx_nib, hi ? eb[7:4] : eb[3:0]);
      if (!hi && b >= 3) m_acc = m_acc ^ eb;
      if (!hi && b >= 4) m_cell++;
      m_nib++;
      if (m_nib == 114) begin
         m_nib = 0;
         m_row++;
         if (m_row == 12) begin
            m_row = 0; m_intrl = 1; m_trl = 0;
         end
      end
   endtask

   task automatic step(input bit tk);
      @(negedge clk);
      chk("R12 valid follows tick", tx_vld, tick_prev);
      if (tx_vld) model_vld();
      if (tx_sof) begin
         g = g + 8'd37;
         rx_febe = g[3:0]; rx_yellow = g[4]; rx_link = g[7:5];
      end
      tick = tk;
      tick_prev = tk;
   endtask

   task automatic run(input int n, input bit gappy);
      for (int i = 0; i < n; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(gappy ? (lfsr[0] | lfsr[3]) : 1'b1);
      end
      step(1'b0);
   endtask

   task automatic set_en(input bit v);
      step(1'b0);
      plcp_en = v;
      m_en = v;
      m_bl = 0;
      model_reset_frame();
   endtask

   task automatic load_sr(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) begin
         step(1'b0);
         ser_en = 1'b1; ser_bit = v[i];
      end
      step(1'b0);
      ser_en = 1'b0;
      m_sr = v;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: all requirements, actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R1 reset valid", tx_vld, 0);
      chk("R1 reset start marker", tx_sof, 0);
      chk("R1 reset take", cell_take, 0);
      rst_n = 1'b1;
      step(1'b0);
      chk("R1 after reset valid", tx_vld, 0);
      chk("R1 after reset take", cell_take, 0);
      chk("R1 after reset start marker", tx_sof, 0);
      // framing, tick every cycle, spare overhead zero
      set_en(1'b1);
      run(4300, 1'b0);
      // gappy ticks with serial overhead override
      load_sr(8'hA5);
      oh_ext = 1'b1;
      run(5600, 1'b1);
      // bypass mode
      set_en(1'b0);
      run(400, 1'b1);
      // re-enable: restart at row 0, phase 0, B1 cleared
      load_sr(8'h3C);
      set_en(1'b1);
      run(3000, 1'b0);
      step(1'b0);
      chk("R4 total bytes taken", src, m_cell);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule